// File: doc/BRIEF.md
# I/O Interrupt Redirection Controller

This block routes up to 24 device interrupt lines to processors. Each line owns a 64-bit redirection entry that sets the vector to deliver, the delivery mode, the destination addressing mode, the polarity, whether the line is edge or level sensitive, a mask bit and an 8-bit destination. Software reaches all entries and the identification registers through two 32-bit locations: a select location at offset 0x00 and a data window at offset 0x10.

The block records a pending request for each line. An edge-sensitive line latches a request on its rising level. A level-sensitive line's request follows the line. A service pass happens when a line rises and one clock after any write to a redirection entry. The pass marks every pending, unmasked line for delivery. Marked lines leave as delivery messages one at a time on a valid/ready handshake, lowest line number first, and each message carries the decoded fields of its entry. Mapping the destination to processors and fetching a vector from a legacy interrupt controller belong to other blocks.

Top module: `irq_router`

## Requirements
- R1: After reset every entry reads low half 0x00010000 (mask set, all other fields zero) and high half 0x00000000, the ID register reads zero and no message is offered.
- R2: Select value 0x00 is the ID register: a window write stores data bits 31:24, and a read returns them in bits 31:24 with all other bits zero.
- R3: Select value 0x01 reads 0x00170011 (version 0x11 in bits 7:0, highest entry index 23 in bits 23:16), and writes to it are ignored. Select 0x02 and any select value past the table (0x40 and up) read zero. A read at offset 0x00 returns the select value in bits 7:0.
- R4: Entry n lives at select 0x10+2n for bits 31:0 and 0x11+2n for bits 63:32. A window write changes only the selected half.
- R5: On an unmasked edge-sensitive line (entry bit 15 = 0), a rising level raises msg_valid in the clock after the sampling edge. The request clears when the message is accepted, so no second message follows. A falling level produces no message.
- R6: On a level-sensitive line (bit 15 = 1), a high level produces one message. The request stays pending after acceptance, and a later entry write produces the message again. Once the line is low, an entry write produces no message.
- R7: A line whose entry has bit 16 set sends nothing but keeps its request. A later write that clears bit 16 causes the message to be sent.
- R8: When several lines are marked, messages leave in increasing line order, one per accepted clock. A lower line that becomes marked while a higher one is stalled is offered first.
- R9: While msg_valid is high and msg_ready is low, the offered message stays valid, as long as the lines and the entries do not change.
- R10: Message fields are taken from the entry: vector from bits 7:0, delivery mode from 10:8, destination mode from 11, polarity from 13, trigger from 15 and destination from 63:56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset: 0x00 select, 0x10 data window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_pin | input | 24 | Interrupt input lines, active high |
| msg_valid | output | 1 | Delivery message offered |
| msg_ready | input | 1 | Consumer accepts the offered message |
| msg_pin | output | 5 | Line number of the message |
| msg_vector | output | 8 | Vector field |
| msg_dlv_mode | output | 3 | Delivery mode field |
| msg_dst_mode | output | 1 | Destination mode field |
| msg_polarity | output | 1 | Polarity field |
| msg_trigger | output | 1 | Trigger field (1 = level) |
| msg_dest | output | 8 | Destination field |

## Verification
A single edge-sensitive line with every message field non-zero shows that the fields map to the right positions. Holding ready low on that line separates a request that waits from one that is lost, and lowering the line shows that a falling level produces nothing. A level-sensitive line is then re-serviced by a bare entry write, once while the line is high and once after it has gone low, which tells a latched request apart from one that follows the line. A masked rising edge followed by an unmask write shows that a masked request is kept, not dropped. Three lines rising in the same clock, and a low line rising behind a stalled high one, test the lowest-first order against arrival order.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  typedef logic [63:0] entry_t;

  // Register offsets of the indirect pair
  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;

  // Select values
  localparam logic [7:0] SEL_ID       = 8'h00;
  localparam logic [7:0] SEL_VER      = 8'h01;
  localparam logic [7:0] SEL_TBL_BASE = 8'h10;

  localparam logic [7:0] VERSION_CODE = 8'h11;

  // Entry field positions
  localparam int unsigned F_VEC   = 0;
  localparam int unsigned F_DLV   = 8;
  localparam int unsigned F_DSTM  = 11;
  localparam int unsigned F_POL   = 13;
  localparam int unsigned F_TRIG  = 15;
  localparam int unsigned F_MASK  = 16;
  localparam int unsigned F_DEST  = 56;

  localparam entry_t ENTRY_RST = entry_t'(1) << F_MASK;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic [7:0]              bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output entry_t [NUM_PINS-1:0]   ent_q,
  output logic                    rescan_o
);
  logic [7:0]            sel_q, sel_d;
  logic [7:0]            id_q, id_d;
  entry_t [NUM_PINS-1:0] ent_d;
  logic                  ent_wr;
  logic                  rescan_q;

  logic [7:0] tbl_off;
  logic [6:0] tbl_idx;
  logic       tbl_hit;
  logic       tbl_hi;

  assign tbl_off = sel_q - SEL_TBL_BASE;
  assign tbl_idx = tbl_off[7:1];
  assign tbl_hi  = tbl_off[0];
  assign tbl_hit = (sel_q >= SEL_TBL_BASE) && (32'(tbl_idx) < NUM_PINS);

  // next state
  always_comb begin
    sel_d  = sel_q;
    id_d   = id_q;
    ent_d  = ent_q;
    ent_wr = 1'b0;
    if (bus_wr && bus_addr == OFS_SEL) sel_d = bus_wdata[7:0];
    if (bus_wr && bus_addr == OFS_WIN) begin
      if (sel_q == SEL_ID) begin
        id_d = bus_wdata[31:24];
      end else if (tbl_hit) begin
        ent_wr = 1'b1;
        for (int n = 0; n < NUM_PINS; n++) begin
          if (tbl_idx == 7'(n)) begin
            if (tbl_hi) ent_d[n][63:32] = bus_wdata;
            else        ent_d[n][31:0]  = bus_wdata;
          end
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      id_q     <= '0;
      rescan_q <= 1'b0;
      for (int n = 0; n < NUM_PINS; n++) ent_q[n] <= ENTRY_RST;
    end else begin
      rescan_q <= ent_wr;
      if (bus_wr) begin
        sel_q <= sel_d;
        id_q  <= id_d;
      end
      if (ent_wr) ent_q <= ent_d;
    end
  end

  assign rescan_o = rescan_q;

  // read path
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_SEL) begin
      bus_rdata = {24'h0, sel_q};
    end else if (bus_addr == OFS_WIN) begin
      if (sel_q == SEL_ID) begin
        bus_rdata = {id_q, 24'h0};
      end else if (sel_q == SEL_VER) begin
        bus_rdata = {8'h0, 8'(NUM_PINS - 1), 8'h0, VERSION_CODE};
      end else if (tbl_hit) begin
        for (int n = 0; n < NUM_PINS; n++) begin
          if (tbl_idx == 7'(n)) bus_rdata = tbl_hi ? ent_q[n][63:32] : ent_q[n][31:0];
        end
      end
    end
  end
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_pin,
  input  logic [NUM_PINS-1:0] level_mode,
  input  logic [NUM_PINS-1:0] mask,
  input  logic                rescan,
  input  logic [NUM_PINS-1:0] take_vec,
  output logic [NUM_PINS-1:0] pend_q,
  output logic [NUM_PINS-1:0] todo_q
);
  logic [NUM_PINS-1:0] pin_q;
  logic [NUM_PINS-1:0] rise;
  logic [NUM_PINS-1:0] pend_d;
  logic [NUM_PINS-1:0] todo_d;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign rise[g]   = irq_pin[g] & ~pin_q[g];
    assign pend_d[g] = level_mode[g] ? irq_pin[g]
                                     : ((pend_q[g] & ~take_vec[g]) | rise[g]);
    assign todo_d[g] = ((todo_q[g] & ~take_vec[g]) | rise[g] | rescan)
                       & pend_d[g] & ~mask[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= '0;
      pend_q <= '0;
      todo_q <= '0;
    end else begin
      pin_q  <= irq_pin;
      pend_q <= pend_d;
      todo_q <= todo_d;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned NUM_PINS = 24,
  localparam int unsigned IDX_W   = $clog2(NUM_PINS)
) (
  input  logic [NUM_PINS-1:0] req,
  output logic                any,
  output logic [NUM_PINS-1:0] onehot,
  output logic [IDX_W-1:0]    idx
);
  always_comb begin
    onehot = '0;
    idx    = '0;
    for (int n = NUM_PINS - 1; n >= 0; n--) begin
      if (req[n]) begin
        onehot    = '0;
        onehot[n] = 1'b1;
        idx       = IDX_W'(n);
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  localparam int unsigned IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [7:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_PINS-1:0] irq_pin,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [IDX_W-1:0]    msg_pin,
  output logic [7:0]          msg_vector,
  output logic [2:0]          msg_dlv_mode,
  output logic                msg_dst_mode,
  output logic                msg_polarity,
  output logic                msg_trigger,
  output logic [7:0]          msg_dest
);
  logic                  rst_sync_n;
  entry_t [NUM_PINS-1:0] ent_w;
  logic                  rescan_w;
  logic [NUM_PINS-1:0]   mask_w, level_w, pend_w, todo_w, req_w;
  logic [NUM_PINS-1:0]   pick_oh, take_vec;
  logic [IDX_W-1:0]      pick_idx;
  logic                  pick_any;
  entry_t                cur;

  irq_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  irq_regfile #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_wr    (reg_wr),
    .bus_addr  (reg_addr),
    .bus_wdata (reg_wdata),
    .bus_rdata (reg_rdata),
    .ent_q     (ent_w),
    .rescan_o  (rescan_w)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_fld
    assign mask_w[g]  = ent_w[g][F_MASK];
    assign level_w[g] = ent_w[g][F_TRIG];
  end

  irq_pending #(.NUM_PINS(NUM_PINS)) u_pend (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .irq_pin    (irq_pin),
    .level_mode (level_w),
    .mask       (mask_w),
    .rescan     (rescan_w),
    .take_vec   (take_vec),
    .pend_q     (pend_w),
    .todo_q     (todo_w)
  );

  assign req_w = todo_w & pend_w & ~mask_w;

  irq_pick #(.NUM_PINS(NUM_PINS)) u_pick (
    .req    (req_w),
    .any    (pick_any),
    .onehot (pick_oh),
    .idx    (pick_idx)
  );

  assign take_vec = pick_oh & {NUM_PINS{msg_ready}};

  always_comb begin
    cur = '0;
    for (int n = 0; n < NUM_PINS; n++) begin
      if (pick_oh[n]) cur = ent_w[n];
    end
  end

  assign msg_valid    = pick_any;
  assign msg_pin      = pick_idx;
  assign msg_vector   = cur[F_VEC +: 8];
  assign msg_dlv_mode = cur[F_DLV +: 3];
  assign msg_dst_mode = cur[F_DSTM];
  assign msg_polarity = cur[F_POL];
  assign msg_trigger  = cur[F_TRIG];
  assign msg_dest     = cur[F_DEST +: 8];
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int unsigned NUM_PINS = 24,
  localparam int unsigned IDX_W   = $clog2(NUM_PINS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic [NUM_PINS-1:0] irq_pin,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [IDX_W-1:0]    msg_pin,
  input logic                msg_trigger,
  input logic [NUM_PINS-1:0] mask_vec,
  input logic [NUM_PINS-1:0] pend_vec,
  input logic [NUM_PINS-1:0] todo_vec
);
  logic [NUM_PINS-1:0] req_c, below;
  assign req_c = todo_vec & pend_vec & ~mask_vec;
  assign below = req_c & ((NUM_PINS'(1) << msg_pin) - NUM_PINS'(1));

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready && !reg_wr && $stable(irq_pin) |=> msg_valid); // R9

  AST_PIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> 32'(msg_pin) < NUM_PINS); // R8

  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> below == '0); // R8

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !mask_vec[msg_pin]); // R7

  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready && !msg_trigger && !reg_wr && $stable(irq_pin)
    |=> !(msg_valid && msg_pin == $past(msg_pin))); // R5
endmodule

bind irq_router irq_router_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .irq_pin     (irq_pin),
  .msg_valid   (msg_valid),
  .msg_ready   (msg_ready),
  .msg_pin     (msg_pin),
  .msg_trigger (msg_trigger),
  .mask_vec    (mask_w),
  .pend_vec    (pend_w),
  .todo_vec    (todo_w)
);

// File: tb/irq_router_bench.sv
module irq_router_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [23:0] irq_pin;
  logic        msg_valid;
  logic        msg_ready;
  logic [4:0]  msg_pin;
  logic [7:0]  msg_vector;
  logic [2:0]  msg_dlv_mode;
  logic        msg_dst_mode;
  logic        msg_polarity;
  logic        msg_trigger;
  logic [7:0]  msg_dest;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_router u_irq_router (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .irq_pin      (irq_pin),
    .msg_valid    (msg_valid),
    .msg_ready    (msg_ready),
    .msg_pin      (msg_pin),
    .msg_vector   (msg_vector),
    .msg_dlv_mode (msg_dlv_mode),
    .msg_dst_mode (msg_dst_mode),
    .msg_polarity (msg_polarity),
    .msg_trigger  (msg_trigger),
    .msg_dest     (msg_dest)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic win_read(input logic [7:0] sel, output logic [31:0] v);
    bus_write(8'h00, {24'h0, sel});
    reg_addr = 8'h10;
    #1;
    v = reg_rdata;
  endtask

  task automatic set_entry(input int pin, input logic [31:0] lo, input logic [31:0] hi);
    bus_write(8'h00, 32'(8'h10 + 2 * pin));
    bus_write(8'h10, lo);
    bus_write(8'h00, 32'(8'h11 + 2 * pin));
    bus_write(8'h10, hi);
  endtask

  // accept the offered message, return at the following negedge
  task automatic accept();
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 no message after reset", msg_valid, 1'b0);
    win_read(8'h10, v); chk("R1 entry0 low", v, 32'h0001_0000);
    win_read(8'h11, v); chk("R1 entry0 high", v, 32'h0);
    win_read(8'h3E, v); chk("R1 entry23 low", v, 32'h0001_0000);
    win_read(8'h00, v); chk("R1 id", v, 32'h0);
  endtask

  task automatic t_idregs();
    logic [31:0] v;
    bus_write(8'h00, 32'h0);
    bus_write(8'h10, 32'hA5FF_FFFF);
    win_read(8'h00, v); chk("R2 id field", v, 32'hA500_0000);
    win_read(8'h01, v); chk("R3 version", v, 32'h0017_0011);
    bus_write(8'h10, 32'hFFFF_FFFF);
    win_read(8'h01, v); chk("R3 version write ignored", v, 32'h0017_0011);
    win_read(8'h02, v); chk("R3 select 2 zero", v, 32'h0);
    win_read(8'h40, v); chk("R3 past table zero", v, 32'h0);
    bus_write(8'h00, 32'h0000_0037);
    reg_addr = 8'h00; #1;
    chk("R3 select readback", reg_rdata, 32'h37);
  endtask

  task automatic t_halves();
    logic [31:0] v;
    set_entry(5, 32'h0001_00AB, 32'h1234_5678);
    win_read(8'h1A, v); chk("R4 entry5 low", v, 32'h0001_00AB);
    win_read(8'h1B, v); chk("R4 entry5 high", v, 32'h1234_5678);
    bus_write(8'h00, 32'h1A);
    bus_write(8'h10, 32'h0001_00CD);
    win_read(8'h1B, v); chk("R4 high kept after low write", v, 32'h1234_5678);
    win_read(8'h1A, v); chk("R4 low updated", v, 32'h0001_00CD);
  endtask

  task automatic t_edge();
    set_entry(3, 32'h0000_2941, 32'h9C00_0000);
    @(negedge clk); irq_pin[3] = 1'b1;
    @(negedge clk);
    chk("R5 valid after rise", msg_valid, 1'b1);
    chk("R5 pin", msg_pin, 5'd3);
    chk("R10 vector", msg_vector, 8'h41);
    chk("R10 delivery mode", msg_dlv_mode, 3'd1);
    chk("R10 dest mode", msg_dst_mode, 1'b1);
    chk("R10 polarity", msg_polarity, 1'b1);
    chk("R10 trigger", msg_trigger, 1'b0);
    chk("R10 dest", msg_dest, 8'h9C);
    repeat (3) @(negedge clk);
    chk("R9 held while stalled", msg_valid, 1'b1);
    chk("R9 same pin while stalled", msg_pin, 5'd3);
    accept();
    chk("R5 cleared after accept", msg_valid, 1'b0);
    irq_pin[3] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 falling gives nothing", msg_valid, 1'b0);
  endtask

  task automatic t_level();
    set_entry(7, 32'h0000_8052, 32'h0);
    @(negedge clk); irq_pin[7] = 1'b1;
    @(negedge clk);
    chk("R6 level valid", msg_valid, 1'b1);
    chk("R6 level pin", msg_pin, 5'd7);
    chk("R10 level trigger", msg_trigger, 1'b1);
    accept();
    chk("R6 sent once", msg_valid, 1'b0);
    bus_write(8'h00, 32'h1F);
    bus_write(8'h10, 32'h0);
    @(negedge clk);
    chk("R6 still pending resent", msg_valid, 1'b1);
    chk("R6 resent pin", msg_pin, 5'd7);
    accept();
    irq_pin[7] = 1'b0;
    @(negedge clk);
    bus_write(8'h10, 32'h0);
    @(negedge clk);
    chk("R6 low clears pending", msg_valid, 1'b0);
  endtask

  task automatic t_mask();
    set_entry(10, 32'h0001_0060, 32'h0);
    @(negedge clk); irq_pin[10] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 masked silent", msg_valid, 1'b0);
    irq_pin[10] = 1'b0;
    bus_write(8'h00, 32'h24);
    bus_write(8'h10, 32'h0000_0060);
    @(negedge clk);
    chk("R7 unmask sends", msg_valid, 1'b1);
    chk("R7 unmask pin", msg_pin, 5'd10);
    chk("R7 unmask vector", msg_vector, 8'h60);
    accept();
    chk("R7 accepted", msg_valid, 1'b0);
  endtask

  task automatic t_order();
    set_entry(2,  32'h22, 32'h0);
    set_entry(9,  32'h29, 32'h0);
    set_entry(20, 32'h34, 32'h0);
    @(negedge clk);
    irq_pin[20] = 1'b1; irq_pin[9] = 1'b1; irq_pin[2] = 1'b1;
    @(negedge clk);
    chk("R8 first pin", msg_pin, 5'd2);
    chk("R8 first vector", msg_vector, 8'h22);
    msg_ready = 1'b1;
    @(negedge clk);
    chk("R8 second pin", msg_pin, 5'd9);
    chk("R8 second vector", msg_vector, 8'h29);
    @(negedge clk);
    chk("R8 third pin", msg_pin, 5'd20);
    @(negedge clk);
    msg_ready = 1'b0;
    chk("R8 drained", msg_valid, 1'b0);
    irq_pin = '0;
    repeat (2) @(negedge clk);
    irq_pin[20] = 1'b1;
    @(negedge clk);
    chk("R8 high alone", msg_pin, 5'd20);
    irq_pin[2] = 1'b1;
    @(negedge clk);
    chk("R8 lower preempts", msg_pin, 5'd2);
    msg_ready = 1'b1;
    @(negedge clk);
    chk("R8 higher after lower", msg_pin, 5'd20);
    @(negedge clk);
    msg_ready = 1'b0;
    chk("R8 both drained", msg_valid, 1'b0);
    irq_pin = '0;
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    irq_pin = '0; msg_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_idregs();
    t_halves();
    t_edge();
    t_level();
    t_mask();
    t_order();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule